// File: doc/BRIEF.md
# One-Wire Bus Bit-Slot Master

This block generates the four bit-level primitives of a one-wire bus master on a single open-drain line with an external pull-up. A caller issues one command at a time: a write-one slot, a write-zero slot, a read slot, or a bus reset that also listens for a presence response. The block pulls the line low through a drive-enable output and never drives it high. It observes the line through a two-flop synchronizer. Each command finishes with a one-cycle done pulse that carries the read bit, the presence flag and a bus-fault flag.

All slot timings are runtime inputs in microseconds. A divider makes a microsecond tick from the system clock. The divider restarts when a command is accepted, so every interval in a slot is measured from the slot start. The read slot does not take one fixed sample. It times the moment the line returns high and compares that moment against a threshold. A reset checks the line for a stuck-low fault both before it drives the pulse and at the end of its window. Byte assembly, ROM commands, device search and speed negotiation belong to the layers above this block.

Top module: `owm_master`

## Requirements
- R1: A write-one command (cmd_op = 0) holds line_pull high for t_low1 µs from acceptance and raises done t_slot + t_rec µs after acceptance.
- R2: A write-zero command (cmd_op = 1) holds line_pull high for t_low0 µs from acceptance and raises done t_slot + t_rec µs after acceptance.
- R3: A read command (cmd_op = 2) pulls for t_lowr µs. If the synchronized line is seen high while fewer than t_rdv µs have elapsed since the slot start, rd_bit is 1 at done.
- R4: In a read, if the line is first seen high at or after t_rdv µs, or stays low until t_rdv + 2 µs, rd_bit is 0 at done.
- R5: A read command raises done t_slot + t_rec µs after acceptance, whatever bit was read.
- R6: A reset command (cmd_op = 3) accepted while the synchronized line is low finishes at once with done and bus_fault = 1, presence = 0, and never asserts line_pull.
- R7: A reset pulls for t_rstl µs. presence at done is 1 when the line is low t_pdh + t_pdl/2 µs after the release, and done comes t_rstl + t_rsth µs after acceptance.
- R8: If the line is still low t_rsth µs after the reset release, done carries bus_fault = 1 and presence = 0.
- R9: rstl_bad is 1 exactly when t_rstl is 960 or more.
- R10: cmd_valid is ignored while busy, and each accepted command yields exactly one done pulse, one cycle wide.
- R11: After reset, line_pull, busy and done are 0. line_pull is only ever asserted while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, accepted when not busy |
| cmd_op | input | 2 | 0 write-one, 1 write-zero, 2 read, 3 reset |
| t_low1 | input | TW | Low time of a write-one slot, µs |
| t_low0 | input | TW | Low time of a write-zero slot, µs |
| t_lowr | input | TW | Low time of a read slot, µs |
| t_rdv | input | TW | Read-valid threshold from slot start, µs |
| t_slot | input | TW | Slot length, µs |
| t_rec | input | TW | Recovery time after a slot, µs |
| t_rstl | input | TW | Reset pulse low time, µs |
| t_rsth | input | TW | Reset window after release, µs |
| t_pdh | input | TW | Presence delay after release, µs |
| t_pdl | input | TW | Presence pulse length, µs |
| line_in | input | 1 | Raw bus line level |
| line_pull | output | 1 | Drive enable; 1 pulls the bus low |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | Read result, valid with done |
| presence | output | 1 | Presence detected, valid with done |
| bus_fault | output | 1 | Stuck-low fault, valid with done |
| rstl_bad | output | 1 | Configured reset low time is too long |

## Verification
The bench places read returns on both sides of the threshold. A return at 13 µs against a 15 µs threshold must read 1. A return at 16 µs, inside the two-microsecond polling grace, must read 0. A design that compared against the timeout instead of the threshold would report 1 there. The stuck-low cases cover both ends of a reset. A low line before the reset must give a fault with no pulse, so a design that skipped the pre-check would drive a full reset. A line held low past the window must give a fault and not a presence. A command poked mid-slot must leave the running slot's timing and its single done untouched. The 959/960 boundary of the reset-length flag is also checked.

// File: rtl/owm_pkg.sv
// Package: shared command codes, controller states and limits for the
// one-wire bit-slot master.
package owm_pkg;

    typedef enum logic [1:0] {
        OP_WR1   = 2'd0,
        OP_WR0   = 2'd1,
        OP_READ  = 2'd2,
        OP_RESET = 2'd3
    } owm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PULL  = 3'd1,
        ST_POLL  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_RWAIT = 3'd4
    } owm_state_e;

    localparam int unsigned RSTL_LIMIT_US = 960;
    localparam int unsigned READ_GRACE_US = 2;

endpackage

// File: rtl/owm_us_tick.sv
// Module: microsecond tick divider.
// Emits a one-cycle tick every CLKS_PER_US clocks. A synchronous clear
// restarts the count, so the first tick comes CLKS_PER_US clocks after
// the clear. Assumes CLKS_PER_US >= 2.
module owm_us_tick #(
    parameter int unsigned CLKS_PER_US = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = $clog2(CLKS_PER_US + 1);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

    logic [CW-1:0] cnt;

    // Divider counter: wraps at LAST, restarts on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);

endmodule

// File: rtl/owm_sync.sv
// Module: multi-stage line synchronizer.
// Brings the asynchronous bus level into the clock domain. Resets to the
// idle (high) level of a pulled-up bus.
module owm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift chain of capture flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/owm_slot_ctrl.sv
// Module: bit-slot sequencer.
// Accepts one command while idle and latches the interval limits for it.
// It then steps through the pull, poll, wait and reset-window phases
// against a microsecond count held since the slot start. Assumes the
// caller keeps t_rsth larger than t_pdh + t_pdl/2 and t_slot + t_rec at
// or above every low time.
module owm_slot_ctrl
    import owm_pkg::*;
#(
    parameter int unsigned TW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [TW-1:0] t_low1,
    input  logic [TW-1:0] t_low0,
    input  logic [TW-1:0] t_lowr,
    input  logic [TW-1:0] t_rdv,
    input  logic [TW-1:0] t_slot,
    input  logic [TW-1:0] t_rec,
    input  logic [TW-1:0] t_rstl,
    input  logic [TW-1:0] t_rsth,
    input  logic [TW-1:0] t_pdh,
    input  logic [TW-1:0] t_pdl,
    input  logic          line_s,
    input  logic          tick,
    output logic          tick_clr,
    output logic          busy,
    output logic          line_pull,
    output logic          done,
    output logic          rd_bit,
    output logic          presence,
    output logic          bus_fault
);
    localparam int unsigned SW = TW + 2;

    owm_state_e     state;
    owm_op_e        op_q;
    logic [SW-1:0]  el;
    logic [SW-1:0]  lim_low, lim_end, lim_rdv, lim_pres;
    logic [SW-1:0]  sel_low, sel_end;
    logic           rd_q, pres_q, pres_taken;
    logic           accept;

    assign accept   = cmd_valid && (state == ST_IDLE);
    assign tick_clr = accept;
    assign busy     = (state != ST_IDLE);
    assign line_pull = (state == ST_PULL);

    // Pick the low time and slot end for the requested command.
    always_comb begin
        unique case (owm_op_e'(cmd_op))
            OP_WR1:   begin sel_low = SW'(t_low1); sel_end = SW'(t_slot) + SW'(t_rec);  end
            OP_WR0:   begin sel_low = SW'(t_low0); sel_end = SW'(t_slot) + SW'(t_rec);  end
            OP_READ:  begin sel_low = SW'(t_lowr); sel_end = SW'(t_slot) + SW'(t_rec);  end
            default:  begin sel_low = SW'(t_rstl); sel_end = SW'(t_rstl) + SW'(t_rsth); end
        endcase
    end

    // Latch the command and its interval limits at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_WR1;
            lim_low  <= '0;
            lim_end  <= '0;
            lim_rdv  <= '0;
            lim_pres <= '0;
        end else if (accept) begin
            op_q     <= owm_op_e'(cmd_op);
            lim_low  <= sel_low;
            lim_end  <= sel_end;
            lim_rdv  <= SW'(t_rdv);
            lim_pres <= SW'(t_rstl) + SW'(t_pdh) + SW'(t_pdl >> 1);
        end
    end

    // Elapsed microseconds since the slot start.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            el <= '0;
        end else if (tick && busy) begin
            el <= el + 1'b1;
        end
    end

    // Phase sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            done       <= 1'b0;
            rd_bit     <= 1'b0;
            presence   <= 1'b0;
            bus_fault  <= 1'b0;
            rd_q       <= 1'b0;
            pres_q     <= 1'b0;
            pres_taken <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        rd_q       <= 1'b0;
                        pres_q     <= 1'b0;
                        pres_taken <= 1'b0;
                        if (owm_op_e'(cmd_op) == OP_RESET && !line_s) begin
                            done      <= 1'b1;
                            rd_bit    <= 1'b0;
                            presence  <= 1'b0;
                            bus_fault <= 1'b1;
                        end else begin
                            state <= ST_PULL;
                        end
                    end
                end
                ST_PULL: begin
                    if (el >= lim_low) begin
                        unique case (op_q)
                            OP_READ:  state <= ST_POLL;
                            OP_RESET: state <= ST_RWAIT;
                            default:  state <= ST_WAIT;
                        endcase
                    end
                end
                ST_POLL: begin
                    if (line_s) begin
                        rd_q  <= (el < lim_rdv);
                        state <= ST_WAIT;
                    end else if (el >= lim_rdv + SW'(READ_GRACE_US)) begin
                        rd_q  <= 1'b0;
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (el >= lim_end) begin
                        state     <= ST_IDLE;
                        done      <= 1'b1;
                        rd_bit    <= (op_q == OP_READ) && rd_q;
                        presence  <= 1'b0;
                        bus_fault <= 1'b0;
                    end
                end
                ST_RWAIT: begin
                    if (!pres_taken && el >= lim_pres) begin
                        pres_q     <= !line_s;
                        pres_taken <= 1'b1;
                    end
                    if (el >= lim_end) begin
                        state     <= ST_IDLE;
                        done      <= 1'b1;
                        rd_bit    <= 1'b0;
                        bus_fault <= !line_s;
                        presence  <= line_s && pres_q;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/owm_master.sv
// Module: one-wire bit-slot master, top level.
// Wires the microsecond divider, the line synchronizer and the slot
// sequencer together, and flags a reset low time that is too long for
// regular speed. Assumes an external pull-up on the bus and an
// open-drain pad driven by line_pull.
module owm_master
    import owm_pkg::*;
#(
    parameter int unsigned CLKS_PER_US = 200,
    parameter int unsigned TW          = 11,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [TW-1:0] t_low1,
    input  logic [TW-1:0] t_low0,
    input  logic [TW-1:0] t_lowr,
    input  logic [TW-1:0] t_rdv,
    input  logic [TW-1:0] t_slot,
    input  logic [TW-1:0] t_rec,
    input  logic [TW-1:0] t_rstl,
    input  logic [TW-1:0] t_rsth,
    input  logic [TW-1:0] t_pdh,
    input  logic [TW-1:0] t_pdl,
    input  logic          line_in,
    output logic          line_pull,
    output logic          busy,
    output logic          done,
    output logic          rd_bit,
    output logic          presence,
    output logic          bus_fault,
    output logic          rstl_bad
);
    logic tick, tick_clr, line_s;

    owm_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    owm_slot_ctrl #(.TW(TW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .t_low1    (t_low1),
        .t_low0    (t_low0),
        .t_lowr    (t_lowr),
        .t_rdv     (t_rdv),
        .t_slot    (t_slot),
        .t_rec     (t_rec),
        .t_rstl    (t_rstl),
        .t_rsth    (t_rsth),
        .t_pdh     (t_pdh),
        .t_pdl     (t_pdl),
        .line_s    (line_s),
        .tick      (tick),
        .tick_clr  (tick_clr),
        .busy      (busy),
        .line_pull (line_pull),
        .done      (done),
        .rd_bit    (rd_bit),
        .presence  (presence),
        .bus_fault (bus_fault)
    );

    // Regular-speed limit on the configured reset low time.
    assign rstl_bad = (32'(t_rstl) >= RSTL_LIMIT_US);

endmodule

// File: rtl/owm_master_chk.sv
// Module: protocol checker for owm_master, attached by bind.
// Watches the top-level ports for open-drain discipline, single done
// pulses, command acceptance and exclusive results.
module owm_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic line_pull,
    input logic done,
    input logic presence,
    input logic bus_fault
);
    // R11: the line is pulled only during a command.
    assert_pull_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_pull);

    // R10: done is a single-cycle pulse.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a pull starts only from a request seen while idle.
    assert_start_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_pull) |-> $past(cmd_valid && !busy));

    // R8: a fault never also reports presence.
    assert_fault_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(presence && bus_fault));

    // R1: the release is followed by more slot time, never by done at once.
    assert_release_in_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_pull) |-> (busy && !done));

endmodule

bind owm_master owm_master_chk u_owm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .line_pull (line_pull),
    .done      (done),
    .presence  (presence),
    .bus_fault (bus_fault)
);

// File: tb/tb_owm_master.sv
// Bench: scoreboard for owm_master. The driver pushes expected results
// into a queue. A monitor pops them on each done and compares the
// results, the slot length and the pull length.
module tb_owm_master;
    localparam int CPU = 4;
    localparam int TW  = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [TW-1:0] t_low1 = 6, t_low0 = 60, t_lowr = 6, t_rdv = 15;
    logic [TW-1:0] t_slot = 65, t_rec = 5, t_rstl = 480, t_rsth = 480;
    logic [TW-1:0] t_pdh = 30, t_pdl = 120;
    logic          slave_low = 1'b0;
    logic          line_pull, busy, done, rd_bit, presence, bus_fault, rstl_bad;
    logic          line_in;

    assign line_in = !(line_pull || slave_low);

    always #2.5 clk = ~clk;

    owm_master #(.CLKS_PER_US(CPU), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .t_low1(t_low1), .t_low0(t_low0), .t_lowr(t_lowr), .t_rdv(t_rdv),
        .t_slot(t_slot), .t_rec(t_rec), .t_rstl(t_rstl), .t_rsth(t_rsth),
        .t_pdh(t_pdh), .t_pdl(t_pdl), .line_in(line_in),
        .line_pull(line_pull), .busy(busy), .done(done), .rd_bit(rd_bit),
        .presence(presence), .bus_fault(bus_fault), .rstl_bad(rstl_bad)
    );

    typedef struct {
        bit    bitv;
        bit    pres;
        bit    fault;
        int    low_us;
        int    end_us;
        int    start;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_bad = 0;
    int   cyc = 0;
    int   pull_cnt = 0;
    int   slave_mode = 0;
    int   slave_us = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Monitor: counts pull cycles and scores every done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (line_pull) pull_cnt++;
            if (done) begin
                if (q.size() == 0) begin
                    check(1'b0, "R10", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    int dur;
                    e = q.pop_front();
                    dur = cyc - e.start;
                    check(rd_bit == e.bitv, e.req, "rd_bit", rd_bit, e.bitv);
                    check(presence == e.pres, e.req, "presence", presence, e.pres);
                    check(bus_fault == e.fault, e.req, "bus_fault", bus_fault, e.fault);
                    check(dur >= e.end_us * CPU && dur <= e.end_us * CPU + 3,
                          e.req, "slot cycles", dur, e.end_us * CPU + 1);
                    check(pull_cnt >= e.low_us * CPU && pull_cnt <= e.low_us * CPU + 2,
                          e.req, "pull cycles", pull_cnt, e.low_us * CPU + 1);
                end
                pull_cnt = 0;
            end
        end
    end

    // Slave model: reacts to each pull according to slave_mode.
    initial begin
        forever begin
            @(posedge line_pull);
            case (slave_mode)
                1: begin
                    slave_low <= 1'b1;
                    repeat (slave_us * CPU) @(posedge clk);
                    slave_low <= 1'b0;
                end
                3: begin
                    @(negedge line_pull);
                    repeat (int'(t_pdh) * CPU) @(posedge clk);
                    slave_low <= 1'b1;
                    repeat (int'(t_pdl) * CPU) @(posedge clk);
                    slave_low <= 1'b0;
                end
                4: begin
                    @(negedge line_pull);
                    slave_low <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Driver: push the expectation, then present one command.
    task automatic issue(input int op, input bit b, input bit p, input bit f,
                         input int low_us, input int end_us, input string req);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        e.bitv = b; e.pres = p; e.fault = f;
        e.low_us = low_us; e.end_us = end_us; e.req = req;
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        @(negedge clk);
        e.start = cyc;
        q.push_back(e);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(!line_pull, "R11", "line_pull after reset", line_pull, 0);
        check(!busy, "R11", "busy after reset", busy, 0);
        check(!done, "R11", "done after reset", done, 0);

        // R1: write-one slot
        issue(0, 0, 0, 0, 6, 70, "R1");
        wait_idle();
        // R2: write-zero slot
        issue(1, 0, 0, 0, 60, 70, "R2");
        wait_idle();

        // R3: slave releases early (5 us) -> 1
        slave_mode = 1; slave_us = 5;
        issue(2, 1, 0, 0, 6, 70, "R3");
        wait_idle();
        // R3: return at 13 us, under the 15 us threshold -> 1
        slave_us = 13;
        issue(2, 1, 0, 0, 6, 70, "R3");
        wait_idle();
        // R4: return at 16 us, inside the grace window -> 0
        slave_us = 16;
        issue(2, 0, 0, 0, 6, 70, "R4");
        wait_idle();
        // R4 R5: held to 25 us, poll times out -> 0, slot length unchanged
        slave_us = 25;
        issue(2, 0, 0, 0, 6, 70, "R5");
        wait_idle();

        // R7: reset with presence pulse
        slave_mode = 3;
        issue(3, 0, 1, 0, 480, 960, "R7");
        wait_idle();
        // R7: reset with no device
        slave_mode = 0;
        issue(3, 0, 0, 0, 480, 960, "R7");
        wait_idle();

        // R6: bus stuck low before reset -> immediate fault, no pull
        slave_low <= 1'b1;
        repeat (4) @(negedge clk);
        issue(3, 0, 0, 1, 0, 0, "R6");
        wait_idle();
        slave_low <= 1'b0;
        repeat (4) @(negedge clk);

        // R8: line stays low after release -> fault instead of presence
        slave_mode = 4;
        issue(3, 0, 0, 1, 480, 960, "R8");
        wait_idle();
        slave_mode = 0;
        slave_low <= 1'b0;
        repeat (4) @(negedge clk);

        // R10: a reset request mid write-zero slot is ignored
        issue(1, 0, 0, 0, 60, 70, "R10");
        repeat (20 * CPU) @(negedge clk);
        cmd_op = 2'd3; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle();
        repeat (50) @(negedge clk);
        check(q.size() == 0 && !busy, "R10", "idle after ignored request", int'(busy), 0);

        // R9: reset low time limit
        t_rstl = 959;
        @(negedge clk);
        check(rstl_bad == 1'b0, "R9", "rstl_bad at 959", rstl_bad, 0);
        t_rstl = 960;
        @(negedge clk);
        check(rstl_bad == 1'b1, "R9", "rstl_bad at 960", rstl_bad, 1);
        t_rstl = 480;

        finish_run();
    end

endmodule